// File: doc/BRIEF.md
# Reset Clock Start-Up Sequencer

This block decides when a small processor core may begin executing after any reset. Four sources are ORed into one reset: power-on, watchdog, brown-out and the external reset pin. While that reset is active, the block returns the clock selection to the primary clock. It also captures the oscillator mode and the two-speed enable, and it freezes both the CPU and the peripheral clocks in the first phase of the instruction cycle.

After the reset is released, a short CPU readiness delay starts, clocked by the reference clock. When the primary clock is one of the crystal types, an oscillator stability count also starts at the same time. That count runs on the primary clock, and its done flag is brought back to the reference domain through a two-flop synchroniser. The holds drop one extra reference cycle after every delay that applies has finished.

With two-speed start-up enabled in a crystal mode, the core does not wait for the oscillator count. It starts on the internal clock, and the block moves the system clock to the primary clock once that clock is stable. A status output reports when the system clock is the stable primary clock.

Top module: `rcs_startup_seq`

## Requirements
- R1: While any reset source is high, the registered outputs take these values one reference edge later: clk_sel = 2'b00 (primary), cpu_hold = 1, periph_hold = 1 and pri_stable = 0.
- R2: For a non-crystal mode, both holds fall exactly CPU_DLY+2 reference edges after the first edge with no reset (default CPU_DLY = 8, so after edge 10). The mode codes are 3 = external clock, 4 = RC and 5 = internal RC.
- R3: For a crystal mode (0 = LP, 1 = XT, 2 = HS) with two-speed off, the holds stay high until at least OST_CYC rising primary-clock edges have passed since reset release. They fall no later than OST_CYC+12 such edges (default OST_CYC = 1024).
- R4: cpu_hold and periph_hold are equal at every reference edge.
- R5: A reset asserted during the sequence raises both holds again. After its release, the timing is the same as after a fresh reset.
- R6: With two-speed on in a crystal mode, the holds fall CPU_DLY+2 edges after release. Until the oscillator count is done, clk_sel = 2'b10 and sys_clk follows iclk. After the count is done, clk_sel = 2'b00 and sys_clk follows pclk.
- R7: In a non-crystal mode, the two-speed enable has no effect, and clk_sel stays 2'b00.
- R8: pri_stable is 1 exactly when the primary clock is selected and stable. In a non-crystal mode it is 1 from the first edge after release. In a crystal mode it becomes 1 only after the oscillator count, and no later than the release of the holds.
- R9: The oscillator mode and two-speed enable are captured only while reset is active. Changes made after release have no effect on the sequence.
- R10: The unused mode codes 6 and 7 behave as non-crystal modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the sequencer and CPU delay |
| pclk | input | 1 | Primary oscillator clock |
| iclk | input | 1 | Internal RC clock |
| por_rst | input | 1 | Power-on reset, active high |
| wdt_rst | input | 1 | Watchdog reset, active high |
| bor_rst | input | 1 | Brown-out reset, active high |
| pin_rst | input | 1 | External pin reset, active high |
| osc_mode | input | 3 | Primary clock mode, captured during reset |
| two_speed_en | input | 1 | Two-speed start-up enable, captured during reset |
| cpu_hold | output | 1 | Holds the CPU in phase 1 |
| periph_hold | output | 1 | Holds peripherals in phase 1 |
| clk_sel | output | 2 | System clock select: 00 primary, 10 internal |
| pri_stable | output | 1 | System clock is the stable primary clock |
| sys_clk | output | 1 | Selected system clock |

## Verification
Every mode code is applied with two-speed both on and off. An exact release on edge CPU_DLY+2 separates the reference-timer-only path from the crystal path, which must wait a window measured in primary-clock edges. Directed runs apply the following:
- a second reset in mid-sequence, to show the timers restart;
- mode and enable changes after release, to show the values are held from reset;
- a two-speed crystal start, which must run on iclk first and then switch to pclk.

Randomly chosen reset sources, reset lengths and interrupting resets show that every source acts the same way.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    MODE_LP    = 3'd0,
    MODE_XT    = 3'd1,
    MODE_HS    = 3'd2,
    MODE_EC    = 3'd3,
    MODE_RC    = 3'd4,
    MODE_INTRC = 3'd5
  } osc_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_EXTRA = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_PRI = 2'b00;
  localparam logic [1:0] SEL_INT = 2'b10;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode == MODE_LP) || (mode == MODE_XT) || (mode == MODE_HS);
  endfunction

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) ff[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk) ff[i] <= ff[i-1];
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rcs_ost_count.sv
module rcs_ost_count #(
  parameter int OST_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic pclk,
  input  logic rst_req,
  output logic done_p
);
  localparam int CW = (OST_CYC > 1) ? $clog2(OST_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(OST_CYC - 1);

  logic          prst;
  logic [CW-1:0] cnt;
  logic          done_q;

  rcs_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (pclk),
    .d   (rst_req),
    .q   (prst)
  );

  always_ff @(posedge pclk) begin
    if (prst) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt    <= cnt + 1'b1;
      done_q <= (cnt == LAST);
    end
  end

  assign done_p = done_q;
endmodule

// File: rtl/rcs_cpu_timer.sv
module rcs_cpu_timer #(
  parameter int CPU_DLY = 8
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(CPU_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(CPU_DLY - 1);

  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt    <= cnt + 1'b1;
      done_q <= (cnt == LAST);
    end
  end

  assign done = done_q;
endmodule

// File: rtl/rcs_startup_seq.sv
module rcs_startup_seq
  import rcs_pkg::*;
#(
  parameter int CPU_DLY     = 8,
  parameter int OST_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pclk,
  input  logic       iclk,
  input  logic       por_rst,
  input  logic       wdt_rst,
  input  logic       bor_rst,
  input  logic       pin_rst,
  input  logic [2:0] osc_mode,
  input  logic       two_speed_en,
  output logic       cpu_hold,
  output logic       periph_hold,
  output logic [1:0] clk_sel,
  output logic       pri_stable,
  output logic       sys_clk
);
  logic       any_rst;
  logic [2:0] mode_q;
  logic       ts_q;
  logic       armed;
  logic       ost_done_p;
  logic       ost_done_s;
  logic       cpu_done;
  logic       xtal;
  logic       ts_xtal;
  logic       osc_ok;
  seq_state_e state, st_nxt;
  logic       cpu_hold_q, per_hold_q, stab_q;
  logic [1:0] sel_q;

  assign any_rst = por_rst | wdt_rst | bor_rst | pin_rst;

  rcs_ost_count #(.OST_CYC(OST_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .pclk    (pclk),
    .rst_req (any_rst),
    .done_p  (ost_done_p)
  );

  rcs_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk (clk),
    .d   (ost_done_p),
    .q   (ost_done_s)
  );

  rcs_cpu_timer #(.CPU_DLY(CPU_DLY)) u_cpu (
    .clk  (clk),
    .rst  (any_rst),
    .done (cpu_done)
  );

  // A stale done flag from an earlier run is ignored until it has been seen low.
  assign xtal    = is_crystal(mode_q);
  assign ts_xtal = ts_q & xtal;
  assign osc_ok  = ~xtal | (armed & ost_done_s);

  always_comb begin
    st_nxt = state;
    case (state)
      ST_WAIT:  if (cpu_done && (ts_xtal || osc_ok)) st_nxt = ST_EXTRA;
      ST_EXTRA: st_nxt = ST_RUN;
      default:  st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      mode_q     <= osc_mode;
      ts_q       <= two_speed_en;
      armed      <= 1'b0;
      state      <= ST_WAIT;
      cpu_hold_q <= 1'b1;
      per_hold_q <= 1'b1;
      sel_q      <= SEL_PRI;
      stab_q     <= 1'b0;
    end else begin
      armed      <= armed | ~ost_done_s;
      state      <= st_nxt;
      cpu_hold_q <= (st_nxt != ST_RUN);
      per_hold_q <= (st_nxt != ST_RUN);
      sel_q      <= (ts_xtal && !osc_ok) ? SEL_INT : SEL_PRI;
      stab_q     <= osc_ok;
    end
  end

  assign cpu_hold    = cpu_hold_q;
  assign periph_hold = per_hold_q;
  assign clk_sel     = sel_q;
  assign pri_stable  = stab_q;
  assign sys_clk     = (sel_q == SEL_INT) ? iclk : pclk;
endmodule

// File: rtl/rcs_startup_chk.sv
module rcs_startup_chk #(
  parameter int CPU_DLY = 8
) (
  input logic       clk,
  input logic       por_rst,
  input logic       wdt_rst,
  input logic       bor_rst,
  input logic       pin_rst,
  input logic       cpu_hold,
  input logic       periph_hold,
  input logic [1:0] clk_sel,
  input logic       pri_stable
);
  logic        rst_any;
  logic [15:0] since_rel;

  assign rst_any = por_rst | wdt_rst | bor_rst | pin_rst;

  always_ff @(posedge clk) begin
    if (rst_any) since_rel <= '0;
    else if (since_rel != 16'hFFFF) since_rel <= since_rel + 16'd1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst_any |=> (clk_sel == 2'b00) && cpu_hold && periph_hold && !pri_stable);

  a_r4_holds_equal: assert property (@(posedge clk) disable iff (rst_any)
    cpu_hold == periph_hold);

  a_r2_min_delay: assert property (@(posedge clk) disable iff (rst_any)
    $fell(cpu_hold) |-> (since_rel >= 16'(CPU_DLY + 2)));

  a_r8_stable_primary: assert property (@(posedge clk) disable iff (rst_any)
    pri_stable |-> (clk_sel == 2'b00));

  a_r6_sel_legal: assert property (@(posedge clk) disable iff (rst_any)
    (clk_sel == 2'b00) || (clk_sel == 2'b10));
endmodule

bind rcs_startup_seq rcs_startup_chk #(.CPU_DLY(CPU_DLY)) u_chk (
  .clk         (clk),
  .por_rst     (por_rst),
  .wdt_rst     (wdt_rst),
  .bor_rst     (bor_rst),
  .pin_rst     (pin_rst),
  .cpu_hold    (cpu_hold),
  .periph_hold (periph_hold),
  .clk_sel     (clk_sel),
  .pri_stable  (pri_stable)
);

// File: tb/rcs_startup_seq_tb.sv
`timescale 1ns/1ps
module rcs_startup_seq_tb_top;
  localparam int CPU_DLY = 8;
  localparam int OST_CYC = 1024;
  localparam int EXACT   = CPU_DLY + 2;

  logic clk = 0, pclk = 0, iclk = 0;
  logic por_rst = 1, wdt_rst = 0, bor_rst = 0, pin_rst = 0;
  logic [2:0] osc_mode = 3'd4;
  logic two_speed_en = 0;
  logic cpu_hold, periph_hold, pri_stable, sys_clk;
  logic [1:0] clk_sel;

  int n_chk = 0, n_fail = 0;
  int pcnt = 0;

  always #4 clk = ~clk;
  always #5 pclk = ~pclk;
  always #6 iclk = ~iclk;
  always @(posedge pclk) pcnt <= pcnt + 1;

  rcs_startup_seq #(.CPU_DLY(CPU_DLY), .OST_CYC(OST_CYC)) dut_i (
    .clk(clk), .pclk(pclk), .iclk(iclk),
    .por_rst(por_rst), .wdt_rst(wdt_rst), .bor_rst(bor_rst), .pin_rst(pin_rst),
    .osc_mode(osc_mode), .two_speed_en(two_speed_en),
    .cpu_hold(cpu_hold), .periph_hold(periph_hold),
    .clk_sel(clk_sel), .pri_stable(pri_stable), .sys_clk(sys_clk)
  );

  function automatic bit exp_exact(input int mode, input bit ts);
    return (mode > 2) || ts;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: por_rst = v;
      1: wdt_rst = v;
      2: bor_rst = v;
      default: pin_rst = v;
    endcase
  endtask

  task automatic do_reset(input int src, input int len, input int mode, input bit ts,
                          output int p0);
    @(negedge clk);
    osc_mode = 3'(mode);
    two_speed_en = ts;
    set_src(src, 1'b1);
    repeat (len) @(negedge clk);
    set_src(src, 1'b0);
    p0 = pcnt;
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    while (cpu_hold && n < limit) begin
      @(posedge clk); @(negedge clk);
      n++;
      check(cpu_hold == periph_hold, "R4 holds equal", periph_hold, cpu_hold);
    end
  endtask

  task automatic follows(input bit use_int, input string tag);
    for (int i = 0; i < 3; i++) begin
      if (use_int) @(posedge iclk); else @(posedge pclk);
      #1 check(sys_clk == 1'b1, tag, sys_clk, 1);
      if (use_int) @(negedge iclk); else @(negedge pclk);
      #1 check(sys_clk == 1'b0, tag, sys_clk, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p0, n, d, mode, src, len;
    bit ts;
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    repeat (20) @(negedge clk);
    check(cpu_hold == 1, "R1 cpu_hold in reset", cpu_hold, 1);
    check(periph_hold == 1, "R1 periph_hold in reset", periph_hold, 1);
    check(clk_sel == 2'b00, "R1 clk_sel in reset", clk_sel, 0);
    check(pri_stable == 0, "R1 pri_stable in reset", pri_stable, 0);
    por_rst = 0;
    p0 = pcnt;

    // R2 + R8 non-crystal exact release
    @(posedge clk); @(negedge clk);
    check(pri_stable == 1, "R8 non-crystal stable after edge 1", pri_stable, 1);
    check(cpu_hold == 1, "R2 hold after edge 1", cpu_hold, 1);
    n = 1;
    while (cpu_hold && n < 100) begin @(posedge clk); @(negedge clk); n++; end
    check(n == EXACT, "R2 release edge RC", n, EXACT);

    // R3 crystal without two-speed
    do_reset(3, 6, 1, 0, p0);
    measure(5000, n);
    d = pcnt - p0;
    check(d >= OST_CYC && d <= OST_CYC + 12, "R3 crystal window", d, OST_CYC);
    check(pri_stable == 1, "R8 stable at crystal release", pri_stable, 1);

    // R8 crystal stable only after osc count
    do_reset(0, 6, 0, 0, p0);
    while (pcnt - p0 < OST_CYC - 50) @(negedge clk);
    check(pri_stable == 0, "R8 not stable before count", pri_stable, 0);
    check(cpu_hold == 1, "R3 hold before count", cpu_hold, 1);
    measure(5000, n);

    // R6 two-speed crystal
    do_reset(2, 5, 2, 1, p0);
    measure(200, n);
    check(n == EXACT, "R6 two-speed release", n, EXACT);
    check(clk_sel == 2'b10, "R6 internal selected", clk_sel, 2);
    check(pri_stable == 0, "R6 not stable yet", pri_stable, 0);
    follows(1, "R6 sys_clk follows iclk");
    while (pcnt - p0 < OST_CYC + 20) @(negedge clk);
    check(clk_sel == 2'b00, "R6 back to primary", clk_sel, 0);
    check(pri_stable == 1, "R8 stable after switch", pri_stable, 1);
    follows(0, "R6 sys_clk follows pclk");

    // R7 two-speed ignored in non-crystal
    do_reset(1, 4, 5, 1, p0);
    measure(200, n);
    check(n == EXACT, "R7 release intrc ts", n, EXACT);
    check(clk_sel == 2'b00, "R7 sel primary", clk_sel, 0);

    // R9 late mode change ignored
    do_reset(3, 4, 4, 0, p0);
    @(posedge clk); @(negedge clk);
    osc_mode = 3'd0; two_speed_en = 1;
    n = 1;
    while (cpu_hold && n < 100) begin
      check(clk_sel == 2'b00, "R9 sel unaffected", clk_sel, 0);
      @(posedge clk); @(negedge clk); n++;
    end
    check(n == EXACT, "R9 release unaffected", n, EXACT);

    // R10 unused codes
    for (int m = 6; m < 8; m++) begin
      do_reset(0, 4, m, 0, p0);
      measure(200, n);
      check(n == EXACT, "R10 unused code release", n, EXACT);
    end

    // R5 mid-sequence reset
    do_reset(0, 4, 3, 0, p0);
    repeat (5) @(negedge clk);
    pin_rst = 1;
    @(posedge clk); @(negedge clk);
    check(cpu_hold == 1, "R5 hold reasserted", cpu_hold, 1);
    @(negedge clk); pin_rst = 0;
    measure(200, n);
    check(n == EXACT, "R5 restart timing", n, EXACT);

    // random trials
    for (int t = 0; t < 24; t++) begin
      mode = int'($urandom_range(0, 7));
      ts   = bit'($urandom_range(0, 1));
      src  = int'($urandom_range(0, 3));
      len  = int'($urandom_range(3, 12));
      do_reset(src, len, mode, ts, p0);
      if ($urandom_range(0, 3) == 0) begin
        repeat (int'($urandom_range(1, CPU_DLY))) @(negedge clk);
        src = int'($urandom_range(0, 3));
        set_src(src, 1'b1);
        @(posedge clk); @(negedge clk);
        check(cpu_hold == 1, "R5 random re-reset hold", cpu_hold, 1);
        repeat (3) @(negedge clk);
        set_src(src, 1'b0);
        p0 = pcnt;
      end
      measure(5000, n);
      if (exp_exact(mode, ts)) begin
        check(n == EXACT, "R2 random exact release", n, EXACT);
      end else begin
        d = pcnt - p0;
        check(d >= OST_CYC && d <= OST_CYC + 12, "R3 random crystal window", d, OST_CYC);
      end
      if (mode > 2) check(clk_sel == 2'b00, "R7 random sel", clk_sel, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule